// File: doc/BRIEF.md
# Cache Maintenance Operation Engine

This block walks the tag state of a four-way set-associative cache on behalf of software. Four 16-bit registers are written over a small register port: the low half of a start address, the high half, a line count, and a command word. A command word with its start bit set launches a walk. The walk visits cache entries one per cycle. Depending on the operation, it fills tags, invalidates entries, marks them dirty, or writes lines back through a request/acknowledge port. `busy` stays high until the walk is done.

The valid, dirty and tag arrays of both the instruction cache and the data cache are held inside the block. A combinational probe port reads any single entry. The data RAM, refill from memory and the processor pipeline live elsewhere. A full-cache operation is issued as one command per way, with the start address at 0 and the count equal to the number of sets minus one.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset, `busy`, `wbReq` and `errSticky` are 0, and the probe port reports every entry of both caches as invalid and clean.
- R2: A write with `regSel`=3 while idle launches a walk, and `busy` is high from the next cycle, when bit 7 (start) is 1 and bits [2:0] are not 010. A command write with bit 7 clear, or with operation 010, leaves `busy` low and changes no entry.
- R3: `regSel` 0 loads address bits [15:0] and `regSel` 1 loads bits [31:16]. The address is aligned down to a 16-byte line. `regSel` 2 holds the line count minus one, so a count of n walks n+1 consecutive lines. The set is address bits [4+SET_W-1:4] and the tag is the bits above the set.
- R4: Command bit 4 enables way select, and bits [6:5] give the way. With bit 4 set, each line acts on that way's entry at the line's set and does no tag compare. With bit 4 clear, each line visits ways 0 to 3 in order, and acts only on a way whose entry is valid and whose tag equals the line's tag.
- R5: Operation 101 (fill) makes the entry valid and clean, and loads it with the walked line's tag. With way select off, it targets way 0.
- R6: Operation 110 (invalidate) clears valid and dirty on acting entries. Operation 111 (mark dirty) sets dirty on acting entries that are valid, and leaves an invalid entry unchanged.
- R7: Operations 000 (write back if dirty), 001 (write back if valid) and 011 (write back if valid, then invalidate) work as follows. An acting entry qualifies when it is valid, and also dirty for 000. A qualifying entry raises `wbReq` with `wbAddr` = {stored tag, set, 4'b0}, and holds both until `wbAck`. The acknowledge clears dirty, and also clears valid for 011. A non-qualifying entry is left as it was.
- R8: Operation 100 (way clear) invalidates and cleans every set of the way in bits [6:5]. It ignores the address, count and way-select-enable bit.
- R9: Command bit 3 picks the cache: 0 is the instruction cache and 1 is the data cache. Entries of the other cache are never changed.
- R10: `busy` is high for exactly one cycle per visited entry. Each write-back adds one cycle, plus one cycle for every cycle that `wbReq` waits for `wbAck`. Way clear visits SETS entries. `wbReq` is only high while `busy` is high.
- R11: A command write while `busy` is high does not disturb the running walk, and it sets `errSticky`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 addr low, 1 addr high, 2 count, 3 command |
| regWdata | input | 16 | Register write data |
| wbAck | input | 1 | Write-back acknowledge |
| probeCache | input | 1 | Probe cache select (0 instruction, 1 data) |
| probeWay | input | $clog2(WAYS) | Probe way |
| probeSet | input | $clog2(SETS) | Probe set |
| busy | output | 1 | Walk in progress |
| errSticky | output | 1 | Command written while busy |
| wbReq | output | 1 | Write-back request |
| wbAddr | output | 32 | Line address of the write-back |
| probeValid | output | 1 | Valid bit of the probed entry |
| probeDirty | output | 1 | Dirty bit of the probed entry |
| probeTag | output | 32-$clog2(SETS)-$clog2(LINE_BYTES) | Tag of the probed entry |

## Verification
The bench builds the engine with 4 ways, 16-byte lines and 16 sets. At that size, a whole-way clear or a full index walk takes 16 cycles, and the bench can probe and compare the entire tag state of both caches after every command. The 24-bit tags this gives still let address-matched walks mix hits and misses across sets. Write-back acknowledges are delayed by zero and by two cycles, which exercises the stall path. A command is injected in the middle of a way clear to reach the busy-write error path.

// File: rtl/cme_pkg.sv
package cme_pkg;
  localparam int ADDR_W = 32;

  localparam logic [1:0] SEL_ADDR_LO = 2'd0;
  localparam logic [1:0] SEL_ADDR_HI = 2'd1;
  localparam logic [1:0] SEL_COUNT   = 2'd2;
  localparam logic [1:0] SEL_CMD     = 2'd3;

  typedef enum logic [2:0] {
    OP_WB_DIRTY   = 3'b000,
    OP_WB_VALID   = 3'b001,
    OP_RESERVED   = 3'b010,
    OP_WB_INV     = 3'b011,
    OP_WAY_CLR    = 3'b100,
    OP_FILL       = 3'b101,
    OP_INV        = 3'b110,
    OP_MARK_DIRTY = 3'b111
  } cmeOp_e;

  // Entry update strobes from control to datapath
  typedef struct packed {
    logic wr;
    logic valid;
    logic dirty;
    logic loadTag;
  } cmeStrobe_t;
endpackage

// File: rtl/cme_dpath.sv
module cme_dpath
  import cme_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 256,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int LN_W = ADDR_W - OFF_W,
  localparam int TAG_W = LN_W - SET_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [15:0]      regWdata,
  input  cmeStrobe_t       strobe,
  input  logic             curCache,
  input  logic [WAY_W-1:0] curWay,
  input  logic [SET_W-1:0] curSet,
  input  logic [TAG_W-1:0] curTag,
  output logic [LN_W-1:0]  startLine,
  output logic [15:0]      lineCount,
  output logic             entValid,
  output logic             entDirty,
  output logic [TAG_W-1:0] entTag,
  input  logic             probeCache,
  input  logic [WAY_W-1:0] probeWay,
  input  logic [SET_W-1:0] probeSet,
  output logic             probeValid,
  output logic             probeDirty,
  output logic [TAG_W-1:0] probeTag
);
  localparam int IDX_W = 1 + WAY_W + SET_W;
  localparam int ENTRIES = 2 * WAYS * SETS;

  logic [15:OFF_W] addrLoUp;
  logic [15:0]     addrHi;
  logic [15:0]     countReg;

  logic [ENTRIES-1:0] validArr;
  logic [ENTRIES-1:0] dirtyArr;
  logic [TAG_W-1:0]   tagArr [ENTRIES];

  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] prIdx;

  assign wrIdx = {curCache, curWay, curSet};
  assign prIdx = {probeCache, probeWay, probeSet};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLoUp <= '0;
      addrHi   <= '0;
      countReg <= '0;
    end else if (regWe) begin
      case (regSel)
        SEL_ADDR_LO: addrLoUp <= regWdata[15:OFF_W];
        SEL_ADDR_HI: addrHi   <= regWdata;
        SEL_COUNT:   countReg <= regWdata;
        default: ;
      endcase
    end
  end

  assign startLine = {addrHi, addrLoUp};
  assign lineCount = countReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
    end else if (strobe.wr) begin
      validArr[wrIdx] <= strobe.valid;
      dirtyArr[wrIdx] <= strobe.dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wr && strobe.loadTag) tagArr[wrIdx] <= curTag;
  end

  assign entValid   = validArr[wrIdx];
  assign entDirty   = dirtyArr[wrIdx];
  assign entTag     = tagArr[wrIdx];
  assign probeValid = validArr[prIdx];
  assign probeDirty = dirtyArr[prIdx];
  assign probeTag   = tagArr[prIdx];
endmodule

// File: rtl/cme_ctrl.sv
module cme_ctrl
  import cme_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 256,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int LN_W = ADDR_W - OFF_W,
  localparam int TAG_W = LN_W - SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [7:0]        cmdWord,
  input  logic [LN_W-1:0]   startLine,
  input  logic [15:0]       lineCount,
  input  logic              entValid,
  input  logic              entDirty,
  input  logic [TAG_W-1:0]  entTag,
  input  logic              wbAck,
  output cmeStrobe_t        strobe,
  output logic              curCache,
  output logic [WAY_W-1:0]  curWay,
  output logic [SET_W-1:0]  curSet,
  output logic [TAG_W-1:0]  curTag,
  output logic              busy,
  output logic              errSticky,
  output logic              wbReq,
  output logic [ADDR_W-1:0] wbAddr
);
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_WBWAIT} state_e;

  state_e           state;
  cmeOp_e           op;
  logic             wayEn;
  logic [WAY_W-1:0] wayIdx;
  logic [WAY_W-1:0] wayCnt;
  logic [LN_W-1:0]  lineNum;
  logic [15:0]      linesLeft;

  logic   cmdWrite, launchOk, singleWay, hit, wbQual, step, lastWay;
  cmeOp_e cmdOp;

  assign cmdWrite = regWe && (regSel == SEL_CMD);
  assign cmdOp    = cmeOp_e'(cmdWord[2:0]);
  assign launchOk = cmdWrite && !busy && cmdWord[7] && (cmdOp != OP_RESERVED);

  assign busy   = (state != ST_IDLE);
  assign wbReq  = (state == ST_WBWAIT);
  assign curSet = lineNum[SET_W-1:0];
  assign curTag = lineNum[LN_W-1:SET_W];

  assign singleWay = wayEn || (op == OP_FILL) || (op == OP_WAY_CLR);
  assign curWay    = !singleWay ? wayCnt :
                     ((op == OP_FILL) && !wayEn) ? '0 : wayIdx;
  assign hit       = singleWay || (entValid && (entTag == curTag));
  assign lastWay   = singleWay || (wayCnt == WAY_W'(WAYS - 1));

  always_comb begin
    case (op)
      OP_WB_DIRTY:            wbQual = hit && entValid && entDirty;
      OP_WB_VALID, OP_WB_INV: wbQual = hit && entValid;
      default:                wbQual = 1'b0;
    endcase
  end

  assign step = ((state == ST_WALK) && !wbQual) || ((state == ST_WBWAIT) && wbAck);

  always_comb begin
    strobe = '0;
    if (state == ST_WBWAIT) begin
      strobe.wr    = wbAck;
      strobe.valid = (op != OP_WB_INV);
      strobe.dirty = 1'b0;
    end else if (state == ST_WALK) begin
      case (op)
        OP_WAY_CLR: strobe.wr = 1'b1;
        OP_FILL: begin
          strobe.wr      = 1'b1;
          strobe.valid   = 1'b1;
          strobe.loadTag = 1'b1;
        end
        OP_INV: strobe.wr = hit;
        OP_MARK_DIRTY: begin
          strobe.wr    = hit && entValid;
          strobe.valid = 1'b1;
          strobe.dirty = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      op        <= OP_WB_DIRTY;
      curCache  <= 1'b0;
      wayEn     <= 1'b0;
      wayIdx    <= '0;
      wayCnt    <= '0;
      lineNum   <= '0;
      linesLeft <= '0;
      errSticky <= 1'b0;
      wbAddr    <= '0;
    end else begin
      if (cmdWrite && busy) errSticky <= 1'b1;
      if (launchOk) begin
        state     <= ST_WALK;
        op        <= cmdOp;
        curCache  <= cmdWord[3];
        wayEn     <= cmdWord[4];
        wayIdx    <= cmdWord[5 +: WAY_W];
        wayCnt    <= '0;
        lineNum   <= (cmdOp == OP_WAY_CLR) ? '0 : startLine;
        linesLeft <= (cmdOp == OP_WAY_CLR) ? 16'(SETS - 1) : lineCount;
      end else if ((state == ST_WALK) && wbQual) begin
        state  <= ST_WBWAIT;
        wbAddr <= {entTag, curSet, OFF_W'(0)};
      end else if (step) begin
        state <= ST_WALK;
        if (!lastWay) begin
          wayCnt <= wayCnt + WAY_W'(1);
        end else begin
          wayCnt <= '0;
          if (linesLeft == 16'd0) begin
            state <= ST_IDLE;
          end else begin
            lineNum   <= lineNum + LN_W'(1);
            linesLeft <= linesLeft - 16'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
  import cme_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 256,
  parameter int LINE_BYTES = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWe,
  input  logic [1:0]               regSel,
  input  logic [15:0]              regWdata,
  input  logic                     wbAck,
  input  logic                     probeCache,
  input  logic [$clog2(WAYS)-1:0]  probeWay,
  input  logic [$clog2(SETS)-1:0]  probeSet,
  output logic                     busy,
  output logic                     errSticky,
  output logic                     wbReq,
  output logic [ADDR_W-1:0]        wbAddr,
  output logic                     probeValid,
  output logic                     probeDirty,
  output logic [ADDR_W-$clog2(SETS)-$clog2(LINE_BYTES)-1:0] probeTag
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int LN_W  = ADDR_W - OFF_W;
  localparam int TAG_W = LN_W - SET_W;

  cmeStrobe_t       strobe;
  logic             curCache;
  logic [WAY_W-1:0] curWay;
  logic [SET_W-1:0] curSet;
  logic [TAG_W-1:0] curTag;
  logic [LN_W-1:0]  startLine;
  logic [15:0]      lineCount;
  logic             entValid;
  logic             entDirty;
  logic [TAG_W-1:0] entTag;

  cme_ctrl #(.WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .cmdWord(regWdata[7:0]), .startLine(startLine), .lineCount(lineCount),
    .entValid(entValid), .entDirty(entDirty), .entTag(entTag), .wbAck(wbAck),
    .strobe(strobe), .curCache(curCache), .curWay(curWay), .curSet(curSet),
    .curTag(curTag), .busy(busy), .errSticky(errSticky), .wbReq(wbReq),
    .wbAddr(wbAddr)
  );

  cme_dpath #(.WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LINE_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .strobe(strobe), .curCache(curCache), .curWay(curWay), .curSet(curSet),
    .curTag(curTag), .startLine(startLine), .lineCount(lineCount),
    .entValid(entValid), .entDirty(entDirty), .entTag(entTag),
    .probeCache(probeCache), .probeWay(probeWay), .probeSet(probeSet),
    .probeValid(probeValid), .probeDirty(probeDirty), .probeTag(probeTag)
  );
endmodule

// File: rtl/cme_checker.sv
module cme_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [1:0]  regSel,
  input logic [7:0]  regCmd,
  input logic        busy,
  input logic        errSticky,
  input logic        wbReq,
  input logic        wbAck,
  input logic [31:0] wbAddr
);
  logic cmdWr;
  assign cmdWr = regWe && (regSel == 2'd3);

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdWr && regCmd[7] && (regCmd[2:0] != 3'b010)) |=> busy);

  assert_no_launch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdWr && (!regCmd[7] || (regCmd[2:0] == 3'b010))) |=> !busy);

  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> (wbReq && $stable(wbAddr)));

  assert_wb_in_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> busy);

  assert_busy_write_err_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busy) |=> errSticky);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);
endmodule

bind cache_maint_engine cme_checker u_cme_checker (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regCmd(regWdata[7:0]),
  .busy(busy), .errSticky(errSticky), .wbReq(wbReq), .wbAck(wbAck), .wbAddr(wbAddr)
);

// File: tb/cache_maint_engine_bench.sv
module cache_maint_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int LINE_BYTES = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWdata = 16'd0;
  logic        wbAck = 1'b0;
  logic        probeCache = 1'b0;
  logic [1:0]  probeWay = 2'd0;
  logic [3:0]  probeSet = 4'd0;
  logic        busy, errSticky, wbReq, probeValid, probeDirty;
  logic [31:0] wbAddr;
  logic [23:0] probeTag;

  int total = 0;
  int bad = 0;

  // Behavioural reference state
  bit          mV [2][4][SETS];
  bit          mD [2][4][SETS];
  logic [23:0] mT [2][4][SETS];
  logic [31:0] wbQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_maint_engine #(.WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LINE_BYTES)) u_cache_maint_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .wbAck(wbAck), .probeCache(probeCache), .probeWay(probeWay), .probeSet(probeSet),
    .busy(busy), .errSticky(errSticky), .wbReq(wbReq), .wbAddr(wbAddr),
    .probeValid(probeValid), .probeDirty(probeDirty), .probeTag(probeTag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkCmd(input logic [2:0] op, input bit c,
                                        input bit wen, input logic [1:0] w);
    return {8'h00, 1'b1, w, wen, c, op};
  endfunction

  task automatic writeReg(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic compareAll(input string req);
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < SETS; s++) begin
          bit ok;
          probeCache = c[0]; probeWay = w[1:0]; probeSet = s[3:0];
          #1;
          ok = (probeValid == mV[c][w][s]) && (probeDirty == mD[c][w][s]) &&
               (!mV[c][w][s] || probeTag == mT[c][w][s]);
          check(ok, req, $sformatf("entry c%0d w%0d s%0d v/d/tag", c, w, s),
                {probeValid, probeDirty, 6'd0, probeTag},
                {mV[c][w][s], mD[c][w][s], 6'd0, mT[c][w][s]});
        end
    @(negedge clk);
  endtask

  // Model one command and return the busy length it produces
  function automatic int modelCmd(input logic [15:0] cmd, input logic [31:0] addr,
                                  input int cnt, input int ackLat);
    int n = 0;
    logic [2:0] op = cmd[2:0];
    int c = cmd[3];
    bit wen = cmd[4];
    int w = cmd[6:5];
    if (!cmd[7] || op == 3'b010) return 0;
    if (op == 3'b100) begin
      for (int s = 0; s < SETS; s++) begin mV[c][w][s] = 0; mD[c][w][s] = 0; end
      return SETS;
    end
    for (int l = 0; l <= cnt; l++) begin
      logic [27:0] ln = addr[31:4] + 28'(l);
      int s = ln[3:0];
      logic [23:0] t = ln[27:4];
      int wLo = wen ? w : 0;
      int wHi = wen ? w : ((op == 3'b101) ? 0 : 3);
      for (int wy = wLo; wy <= wHi; wy++) begin
        bit hit = (wen || op == 3'b101) ? 1'b1 : (mV[c][wy][s] && mT[c][wy][s] == t);
        bit wb;
        n++;
        wb = hit && mV[c][wy][s] && ((op == 3'b000) ? mD[c][wy][s] : (op == 3'b001 || op == 3'b011));
        if (wb) begin
          wbQ.push_back({mT[c][wy][s], s[3:0], 4'h0});
          n += 1 + ackLat;
          mD[c][wy][s] = 0;
          if (op == 3'b011) mV[c][wy][s] = 0;
        end else if (op == 3'b101) begin
          mV[c][wy][s] = 1; mD[c][wy][s] = 0; mT[c][wy][s] = t;
        end else if (op == 3'b110 && hit) begin
          mV[c][wy][s] = 0; mD[c][wy][s] = 0;
        end else if (op == 3'b111 && hit && mV[c][wy][s]) begin
          mD[c][wy][s] = 1;
        end
      end
    end
    return n;
  endfunction

  task automatic runCmd(input string req, input logic [15:0] cmd, input logic [31:0] addr,
                        input int cnt, input int ackLat, input int injectAt);
    int n;
    int waitCnt = 0;
    writeReg(2'd0, addr[15:0]);
    writeReg(2'd1, addr[31:16]);
    writeReg(2'd2, 16'(cnt));
    n = modelCmd(cmd, addr, cnt, ackLat);
    @(negedge clk);
    regWe = 1'b1; regSel = 2'd3; regWdata = cmd;
    @(negedge clk);
    regWe = 1'b0;
    for (int k = 0; k < n; k++) begin
      regWe = 1'b0;
      check(busy == 1'b1, "R10", $sformatf("busy in walk cycle %0d", k), 32'(busy), 32'd1);
      if (wbReq) begin
        if (waitCnt == ackLat) begin
          logic [31:0] e = (wbQ.size() > 0) ? wbQ.pop_front() : 32'hDEADBEEF;
          check(wbAddr == e, "R7", "write-back address", wbAddr, e);
          wbAck = 1'b1;
        end else begin
          waitCnt++;
          wbAck = 1'b0;
        end
      end else begin
        wbAck = 1'b0;
        waitCnt = 0;
      end
      if (k == injectAt) begin
        regWe = 1'b1; regSel = 2'd3; regWdata = mkCmd(3'b101, 1'b1, 1'b1, 2'd3);
      end
      @(negedge clk);
    end
    regWe = 1'b0;
    wbAck = 1'b0;
    check(busy == 1'b0, req, "busy low after walk", 32'(busy), 32'd0);
    check(wbQ.size() == 0, req, "all write-backs seen", 32'(wbQ.size()), 32'd0);
    compareAll(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < SETS; s++) begin mV[c][w][s] = 0; mD[c][w][s] = 0; mT[c][w][s] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1", "busy after reset", 32'(busy), 0);
    check(wbReq == 0, "R1", "wbReq after reset", 32'(wbReq), 0);
    check(errSticky == 0, "R1", "errSticky after reset", 32'(errSticky), 0);
    compareAll("R1");

    // R2: command without start bit, and reserved op, do not launch
    runCmd("R2", 16'h00_2D, 32'h0001_2340, 3, 0, -1);
    runCmd("R2", mkCmd(3'b010, 1'b1, 1'b1, 2'd0), 32'h0001_2340, 3, 0, -1);
    check(errSticky == 0, "R2", "no error from idle writes", 32'(errSticky), 0);

    // R4 R5: fill data cache way 2 by index, 4 lines
    runCmd("R5", mkCmd(3'b101, 1'b1, 1'b1, 2'd2), 32'h0001_2340, 3, 0, -1);
    // R5: fill without way select lands in way 0
    runCmd("R5", mkCmd(3'b101, 1'b1, 1'b0, 2'd3), 32'h0004_5670, 1, 0, -1);
    // R3 R9: unaligned address into instruction cache
    runCmd("R3", mkCmd(3'b101, 1'b0, 1'b1, 2'd1), 32'h0001_2345, 0, 0, -1);
    // R6 R4: mark dirty by tag match over 6 lines (hits and misses)
    runCmd("R6", mkCmd(3'b111, 1'b1, 1'b0, 2'd0), 32'h0001_2340, 5, 0, -1);
    // R6: mark dirty on an invalid entry has no effect
    runCmd("R6", mkCmd(3'b111, 1'b1, 1'b1, 2'd3), 32'h0000_0000, 0, 0, -1);
    // R7 R10: write back dirty with a two-cycle acknowledge delay
    runCmd("R7", mkCmd(3'b000, 1'b1, 1'b0, 2'd0), 32'h0001_2340, 5, 2, -1);
    // R7: mark way 0 set 7 dirty, then write back valid and invalidate whole way 2
    runCmd("R6", mkCmd(3'b111, 1'b1, 1'b1, 2'd0), 32'h0004_5670, 0, 0, -1);
    runCmd("R7", mkCmd(3'b011, 1'b1, 1'b1, 2'd2), 32'h0000_0000, SETS - 1, 0, -1);
    // R7: write back valid by tag match, clean entries also qualify
    runCmd("R7", mkCmd(3'b001, 1'b1, 1'b0, 2'd0), 32'h0004_5670, 1, 1, -1);
    // R9 R6: invalidate in instruction cache leaves data cache untouched
    runCmd("R9", mkCmd(3'b110, 1'b0, 1'b0, 2'd0), 32'h0001_2340, 0, 0, -1);
    // R8 R11: way clear ignores address and count; command injected while busy
    runCmd("R8", mkCmd(3'b100, 1'b1, 1'b0, 2'd0), 32'h000F_FFF0, 7, 0, 4);
    check(errSticky == 1, "R11", "errSticky after busy write", 32'(errSticky), 1);
    repeat (3) @(negedge clk);
    check(errSticky == 1, "R11", "errSticky holds", 32'(errSticky), 1);
    check(busy == 0, "R11", "injected command not launched", 32'(busy), 0);
    // R3: line count wraps across the top of the address space
    runCmd("R3", mkCmd(3'b101, 1'b0, 1'b0, 2'd0), 32'hFFFF_FFF8, 1, 0, -1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule